// File: doc/BRIEF.md
# Panel Register Write Sequencer

This block programs a small display controller over a four-wire serial link in SPI mode 0, on which it only transmits. A register write is never sent as a single transfer. It goes out as two chip-select frames of 24 bits each:

- an **index frame**, which names the target register;
- a **data frame**, which carries the 16-bit value.

Each frame is framed by its own chip-select window, and the two are separated by an idle gap.

A small command controller sits on top of this write primitive and offers four operations:

- a raw single-register write;
- a power-up sequence;
- a power-down sequence;
- a wake-up sequence that replays the output-control word saved by the last power-up.

The requester issues a command with a one-cycle valid strobe. It then watches a busy level and a one-cycle completion pulse. Commands issued while busy is high are dropped.

Top module: `panel_reg_sequencer`

## Requirements
- R1: The index frame is 24 bits, sent MSB first inside one chip-select low window. It carries 0x74, then 0x00, then the 8-bit register number.
- R2: The data frame is 24 bits, sent MSB first inside one chip-select low window. It carries 0x76, then the high byte of the value, then the low byte.
- R3: For every register write, the index frame is sent before the data frame. Between any two frames, chip select stays high for at least one serial clock period (2*CLK_DIV cycles).
- R4: The link uses SPI mode 0. The serial clock is low whenever chip select is high. MOSI never changes while the serial clock is high. Every high phase of the serial clock lasts exactly CLK_DIV cycles.
- R5: Command code 0 writes `cmd_reg` with `cmd_value`, as one index frame followed by one data frame.
- R6: Command code 1 (power-up) writes register 0x11 with 0x0000. It then writes register 0x01 with the output-control word.
- R7: The output-control word is `(mode_req & MODE_KEEP) | (0x2AEF & ~MODE_KEEP)`, with MODE_KEEP = 0x3300 by default. Power-up stores this word for later wake-ups.
- R8: Command code 2 (power-down) writes register 0x11 with 0x0001.
- R9: Command code 3 (wake-up) writes register 0x01 with the stored word, then writes register 0x11 with 0x0000. Before any power-up, the stored word is 0x08EF.
- R10: `busy` goes high on the cycle after a command is accepted. A `cmd_valid` seen while `busy` is high produces no frame and no `done`.
- R11: `done` is high for exactly one cycle per accepted command. That cycle comes after the last frame's chip-select gap, and `busy` is low in it.
- R12: After reset, `busy` = 0, `done` = 0, `spi_csn` = 1, `spi_sclk` = 0 and `spi_mosi` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe; accepted only while not busy |
| cmd_op | input | 2 | Command code: 0 write, 1 power-up, 2 power-down, 3 wake-up |
| cmd_reg | input | 8 | Register number for command code 0 |
| cmd_value | input | 16 | Value for command code 0 |
| mode_req | input | 16 | Requested output-control bits, used by power-up |
| busy | output | 1 | High while a command is in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_csn | output | 1 | Active-low chip select |

## Verification
The bench builds the block with CLK_DIV = 2 and the default MODE_KEEP of 0x3300. At this divider a two-frame command takes only about two hundred cycles, so a few dozen directed and random commands fit in a short run. The short divider also makes every half-period and chip-select gap only a handful of cycles long, so any off-by-one in those counts is visible.

The default mask splits 0x2AEF into kept bits and forced bits. Power-up words built from all-ones, all-zeros and mixed requests then show which bits pass through and which are forced.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_PWR_ON = 2'd1,
    OP_SHUT   = 2'd2,
    OP_RESUME = 2'd3
  } seq_op_e;

  localparam logic [7:0]  LEAD_INDEX = 8'h74;
  localparam logic [7:0]  LEAD_DATA  = 8'h76;
  localparam logic [7:0]  REG_POWER  = 8'h11;
  localparam logic [7:0]  REG_OUTCTL = 8'h01;
  localparam logic [15:0] PWR_RUN    = 16'h0000;
  localparam logic [15:0] PWR_OFF    = 16'h0001;
  localparam logic [15:0] OUTCTL_BASE = 16'h2AEF;

  function automatic logic [15:0] build_mode(input logic [15:0] req,
                                             input logic [15:0] keep);
    return (req & keep) | (OUTCTL_BASE & ~keep);
  endfunction
endpackage

// File: rtl/spi_frame_tx.sv
module spi_frame_tx #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  fin,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  csn
);
  localparam int GAP_LEN = 2 * CLK_DIV;
  localparam int DW = $clog2(GAP_LEN + 1);
  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [DW-1:0] HALF_LAST = DW'(CLK_DIV - 1);
  localparam logic [DW-1:0] GAP_LAST  = DW'(GAP_LEN - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_LOW, TX_HIGH, TX_GAP} tx_st_e;

  tx_st_e                st;
  logic [DW-1:0]         div_cnt;
  logic [BW-1:0]         bit_cnt;
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TX_IDLE;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      fin     <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      csn     <= 1'b1;
    end else begin
      fin <= 1'b0;
      case (st)
        TX_IDLE: begin
          if (start) begin
            shreg   <= frame;
            mosi    <= frame[FRAME_BITS-1];
            csn     <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            st      <= TX_LOW;
          end
        end
        TX_LOW: begin
          if (div_cnt == HALF_LAST) begin
            div_cnt <= '0;
            sclk    <= 1'b1;
            st      <= TX_HIGH;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        TX_HIGH: begin
          if (div_cnt == HALF_LAST) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
            if (bit_cnt == BIT_LAST) begin
              csn  <= 1'b1;
              mosi <= 1'b0;
              st   <= TX_GAP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
              mosi    <= shreg[FRAME_BITS-2];
              st      <= TX_LOW;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: begin
          if (div_cnt == GAP_LAST) begin
            div_cnt <= '0;
            fin     <= 1'b1;
            st      <= TX_IDLE;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/reg_write_engine.sv
module reg_write_engine
  import panel_seq_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_start,
  input  logic [7:0]  wr_reg,
  input  logic [15:0] wr_val,
  output logic        wr_done,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_csn
);
  localparam int FRAME_BITS = 24;

  typedef enum logic [1:0] {WE_IDLE, WE_INDEX, WE_DATA} we_st_e;

  we_st_e                st;
  logic                  tx_start;
  logic                  tx_fin;
  logic [FRAME_BITS-1:0] tx_frame;
  logic [15:0]           val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= WE_IDLE;
      tx_start <= 1'b0;
      tx_frame <= '0;
      val_q    <= '0;
      wr_done  <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      wr_done  <= 1'b0;
      case (st)
        WE_IDLE: begin
          if (wr_start) begin
            val_q    <= wr_val;
            tx_frame <= {LEAD_INDEX, 8'h00, wr_reg};
            tx_start <= 1'b1;
            st       <= WE_INDEX;
          end
        end
        WE_INDEX: begin
          if (tx_fin) begin
            tx_frame <= {LEAD_DATA, val_q};
            tx_start <= 1'b1;
            st       <= WE_DATA;
          end
        end
        default: begin
          if (tx_fin) begin
            wr_done <= 1'b1;
            st      <= WE_IDLE;
          end
        end
      endcase
    end
  end

  spi_frame_tx #(
    .CLK_DIV   (CLK_DIV),
    .FRAME_BITS(FRAME_BITS)
  ) u_tx (
    .clk  (clk),
    .rst  (rst),
    .start(tx_start),
    .frame(tx_frame),
    .fin  (tx_fin),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .csn  (spi_csn)
  );
endmodule

// File: rtl/power_seq_ctrl.sv
module power_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter logic [15:0] MODE_KEEP = 16'h3300
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_reg,
  input  logic [15:0] cmd_value,
  input  logic [15:0] mode_req,
  input  logic        wr_done,
  output logic        wr_start,
  output logic [7:0]  wr_reg,
  output logic [15:0] wr_val,
  output logic        busy,
  output logic        done
);
  localparam int MAX_STEPS = 2;
  localparam int SW = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;
  localparam logic [15:0] MODE_RESET = OUTCTL_BASE & ~MODE_KEEP;

  seq_op_e op;
  assign op = seq_op_e'(cmd_op);

  logic [MAX_STEPS-1:0][7:0]  plan_reg, step_reg;
  logic [MAX_STEPS-1:0][15:0] plan_val, step_val;
  logic [SW-1:0]              plan_last, step_last, step_idx;
  logic [15:0]                fresh_mode, saved_mode;

  assign fresh_mode = build_mode(mode_req, MODE_KEEP);

  always_comb begin
    plan_reg  = '0;
    plan_val  = '0;
    plan_last = '0;
    case (op)
      OP_PWR_ON: begin
        plan_reg[0] = REG_POWER;  plan_val[0] = PWR_RUN;
        plan_reg[1] = REG_OUTCTL; plan_val[1] = fresh_mode;
        plan_last   = SW'(1);
      end
      OP_SHUT: begin
        plan_reg[0] = REG_POWER;  plan_val[0] = PWR_OFF;
      end
      OP_RESUME: begin
        plan_reg[0] = REG_OUTCTL; plan_val[0] = saved_mode;
        plan_reg[1] = REG_POWER;  plan_val[1] = PWR_RUN;
        plan_last   = SW'(1);
      end
      default: begin
        plan_reg[0] = cmd_reg;    plan_val[0] = cmd_value;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      wr_start   <= 1'b0;
      wr_reg     <= '0;
      wr_val     <= '0;
      step_reg   <= '0;
      step_val   <= '0;
      step_last  <= '0;
      step_idx   <= '0;
      saved_mode <= MODE_RESET;
    end else begin
      done     <= 1'b0;
      wr_start <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy      <= 1'b1;
          step_reg  <= plan_reg;
          step_val  <= plan_val;
          step_last <= plan_last;
          step_idx  <= '0;
          wr_reg    <= plan_reg[0];
          wr_val    <= plan_val[0];
          wr_start  <= 1'b1;
          if (op == OP_PWR_ON) saved_mode <= fresh_mode;
        end
      end else if (wr_done) begin
        if (step_idx == step_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step_idx <= step_idx + 1'b1;
          wr_reg   <= step_reg[step_idx + 1'b1];
          wr_val   <= step_val[step_idx + 1'b1];
          wr_start <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/panel_reg_sequencer.sv
module panel_reg_sequencer #(
  parameter int          CLK_DIV   = 4,
  parameter logic [15:0] MODE_KEEP = 16'h3300
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_reg,
  input  logic [15:0] cmd_value,
  input  logic [15:0] mode_req,
  output logic        busy,
  output logic        done,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_csn
);
  logic        wr_start, wr_done;
  logic [7:0]  wr_reg;
  logic [15:0] wr_val;

  power_seq_ctrl #(.MODE_KEEP(MODE_KEEP)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_reg  (cmd_reg),
    .cmd_value(cmd_value),
    .mode_req (mode_req),
    .wr_done  (wr_done),
    .wr_start (wr_start),
    .wr_reg   (wr_reg),
    .wr_val   (wr_val),
    .busy     (busy),
    .done     (done)
  );

  reg_write_engine #(.CLK_DIV(CLK_DIV)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .wr_start(wr_start),
    .wr_reg  (wr_reg),
    .wr_val  (wr_val),
    .wr_done (wr_done),
    .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi),
    .spi_csn (spi_csn)
  );
endmodule

// File: rtl/panel_seq_checker.sv
module panel_seq_checker #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_csn
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= 16'hFFFF;
    else if (spi_csn) begin
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end else hi_cnt <= '0;
  end

  AST_CS_GAP_LONG: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_csn) |-> (hi_cnt >= 16'(2 * CLK_DIV))); // R3
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    spi_csn |-> !spi_sclk); // R4
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && spi_csn)); // R11
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R11
endmodule

bind panel_reg_sequencer panel_seq_checker #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi),
  .spi_csn (spi_csn)
);

// File: tb/sim_panel_reg_sequencer.sv
`timescale 1ns/1ps
module sim_panel_reg_sequencer;
  localparam int CLK_DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_reg = 8'd0;
  logic [15:0] cmd_value = 16'd0;
  logic [15:0] mode_req = 16'd0;
  logic busy, done, spi_sclk, spi_mosi, spi_csn;

  always #2 clk = ~clk;

  panel_reg_sequencer #(.CLK_DIV(CLK_DIV), .MODE_KEEP(16'h3300)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_value(cmd_value), .mode_req(mode_req),
    .busy(busy), .done(done), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_csn(spi_csn)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // frame capture: {bit count, 24-bit payload}
  logic [31:0] got_q[$];
  logic [23:0] exp_q[$];
  logic [23:0] cur = '0;
  int nbits = 0;

  always @(negedge spi_csn) begin cur = '0; nbits = 0; end
  always @(posedge spi_sclk) if (!spi_csn) begin
    cur = {cur[22:0], spi_mosi};
    nbits++;
  end
  always @(posedge spi_csn) if (nbits != 0) begin
    got_q.push_back({8'(nbits), cur});
    nbits = 0;
  end

  // line monitors sampled away from the active edge
  int done_cnt = 0, done_busy_bad = 0, bad_half = 0, bad_mosi = 0, bad_idle = 0;
  int hi_run = 0, sclk_run = 0, min_gap = 1000000;
  logic prev_csn = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) if (!rst) begin
    if (done) begin
      done_cnt++;
      if (busy) done_busy_bad++;
    end
    if (spi_csn && spi_sclk) bad_idle++;
    if (spi_sclk && prev_sclk && (spi_mosi != prev_mosi)) bad_mosi++;
    if (spi_sclk) sclk_run++;
    else begin
      if (prev_sclk && sclk_run != CLK_DIV) bad_half++;
      sclk_run = 0;
    end
    if (spi_csn) hi_run++;
    else begin
      if (prev_csn && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
    prev_csn = spi_csn; prev_sclk = spi_sclk; prev_mosi = spi_mosi;
  end

  // reference model
  logic [15:0] model_mode = 16'h08EF;

  function automatic logic [15:0] ref_mode(input logic [15:0] m);
    return (m & 16'h3300) | (16'h2AEF & ~16'h3300);
  endfunction

  function automatic void push_write(input logic [7:0] r, input logic [15:0] v);
    exp_q.push_back({8'h74, 8'h00, r});
    exp_q.push_back({8'h76, v});
  endfunction

  function automatic void plan_op(input logic [1:0] op, input logic [7:0] r,
                                  input logic [15:0] v, input logic [15:0] m);
    case (op)
      2'd0: push_write(r, v);
      2'd1: begin
        push_write(8'h11, 16'h0000);
        model_mode = ref_mode(m);
        push_write(8'h01, model_mode);
      end
      2'd2: push_write(8'h11, 16'h0001);
      default: begin
        push_write(8'h01, model_mode);
        push_write(8'h11, 16'h0000);
      end
    endcase
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [7:0] r,
                       input logic [15:0] v, input logic [15:0] m,
                       input bit poke, input string tag);
    int d0;
    int guard;
    got_q.delete();
    exp_q.delete();
    plan_op(op, r, v, m);
    d0 = done_cnt;
    @(negedge clk);
    cmd_op = op; cmd_reg = r; cmd_value = v; mode_req = m; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, {tag, " R10 busy after accept"}, busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      cmd_op = 2'd0; cmd_reg = 8'h5A; cmd_value = 16'hDEAD; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd2;
      repeat (20) @(negedge clk);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chk(done_cnt - d0 == 1, {tag, " R11 done count"}, done_cnt - d0, 1);
    chk(got_q.size() == exp_q.size(), {tag, " R10 frame count"},
        got_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      if (i < got_q.size()) begin
        chk(got_q[i][31:24] == 8'd24, {tag, " R1/R2 frame length"},
            got_q[i][31:24], 24);
        chk(got_q[i][23:0] == exp_q[i],
            {tag, (i % 2 == 0) ? " R1 R3 index frame" : " R2 R3 data frame"},
            got_q[i][23:0], exp_q[i]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk({busy, done, spi_csn, spi_sclk, spi_mosi} == 5'b00100, "R12 reset outputs",
        {busy, done, spi_csn, spi_sclk, spi_mosi}, 5'b00100);

    do_op(2'd0, 8'h00, 16'h0000, 16'h0, 1'b0, "R5 zero write");
    do_op(2'd0, 8'hFF, 16'hFFFF, 16'h0, 1'b0, "R5 ones write");
    do_op(2'd3, 8'h00, 16'h0000, 16'h0, 1'b0, "R9 wake before power-up");
    do_op(2'd1, 8'h00, 16'h0000, 16'hFFFF, 1'b0, "R6 R7 power-up all ones");
    do_op(2'd3, 8'h00, 16'h0000, 16'h0, 1'b0, "R9 wake after power-up");
    do_op(2'd1, 8'h00, 16'h0000, 16'hCCFF, 1'b0, "R7 power-up masked out");
    do_op(2'd1, 8'h00, 16'h0000, 16'h5A5A, 1'b0, "R7 power-up mixed");
    do_op(2'd2, 8'h00, 16'h0000, 16'h0, 1'b0, "R8 power-down");
    do_op(2'd0, 8'hA5, 16'h1234, 16'h0, 1'b1, "R10 ignored while busy");
    do_op(2'd3, 8'h00, 16'h0000, 16'h0, 1'b1, "R9 R10 wake with poke");

    for (int k = 0; k < 24; k++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      do_op(op, 8'($urandom), 16'($urandom), 16'($urandom),
            ($urandom % 4) == 0, "R5 random");
    end

    chk(bad_idle == 0, "R4 sclk low while csn high", bad_idle, 0);
    chk(bad_mosi == 0, "R4 mosi stable while sclk high", bad_mosi, 0);
    chk(bad_half == 0, "R4 sclk high phase length", bad_half, 0);
    chk(min_gap >= 2 * CLK_DIV, "R3 csn gap", min_gap, 2 * CLK_DIV);
    chk(done_busy_bad == 0, "R11 busy low with done", done_busy_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule